// File: doc/BRIEF.md
# Pipelined Request Intake Queue

This block sits on the target side of a graphics bus. It accepts queued transaction requests from the bus master and holds them in an 8-entry FIFO, which the downstream memory controller drains. Requests arrive by one of two entry paths:

- **Strobe path.** While an active-low pipe strobe is held, one full-width address and command is taken from the shared bus on every rising clock edge.
- **Sideband path.** An 8-bit side bus delivers each request as four qualified beats.

Only one path is ever live. Software writes the path choice once after reset. That write locks the choice until the next reset. Until the write happens, no request is accepted.

Each queued entry carries a 32-bit address and a 4-bit command. Entries leave through a valid/ready port:

- An entry is presented while `deq_valid` is high.
- It is consumed on a clock edge where `deq_valid` and `deq_ready` are both high.
- While `deq_ready` is low, the presented entry stays unchanged.
- The intake side has no back-pressure. A request that finds the FIFO full is dropped, and a sticky error flag is set.

Top module: `req_intake_queue`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, `deq_valid`=0, `overflow`=0, `cfg_locked`=0 and `mode_sb`=0.
- R2: The first clock edge with `cfg_wr`=1 loads `cfg_sel` into `mode_sb` (0 = strobe path, 1 = sideband path) and sets `cfg_locked`. Later writes are ignored until reset.
- R3: While `cfg_locked`=0, no request is enqueued from either path.
- R4: In strobe mode, every rising edge with `pipe_n`=0 enqueues {`ad_in`, `cmd_in`} as one entry.
- R5: In strobe mode, an edge with `pipe_n`=1 enqueues nothing.
- R6: In strobe mode, sideband activity (`sb_vld`, `sb_data`) has no effect.
- R7: In sideband mode, qualified beats (`sb_vld`=1) are assembled into one request:
  - beat 0 gives cmd = `sb_data[3:0]`;
  - beats 1, 2 and 3 give addr[31:24], addr[23:16] and addr[15:8];
  - addr[7:0] is 0.
  The request is enqueued on the edge of beat 3. `pipe_n` has no effect in this mode.
- R8: Entries leave in arrival order. `q_full` is high exactly when 8 entries are held, and `q_empty` exactly when none are.
- R9: An enqueue attempt while `q_full`=1 is dropped and sets `overflow`. This holds even when a dequeue happens in the same cycle. `overflow` stays set until reset.
- R10: `deq_valid` is high whenever the FIFO is non-empty. While `deq_ready`=0, the presented entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Path-select write strobe |
| cfg_sel | input | 1 | Path to select: 0 strobe, 1 sideband |
| cfg_locked | output | 1 | Path choice has been written |
| mode_sb | output | 1 | Selected path is sideband |
| pipe_n | input | 1 | Active-low pipe strobe |
| ad_in | input | 32 | Full-width request address |
| cmd_in | input | 4 | Full-width request command |
| sb_vld | input | 1 | Sideband beat qualifier |
| sb_data | input | 8 | Sideband beat data |
| deq_valid | output | 1 | Head entry present |
| deq_ready | input | 1 | Consumer accepts head entry |
| deq_addr | output | 32 | Head entry address |
| deq_cmd | output | 4 | Head entry command |
| q_full | output | 1 | FIFO holds 8 entries |
| q_empty | output | 1 | FIFO holds no entries |
| overflow | output | 1 | Sticky dropped-request flag |

## Verification
Strobe bursts of different lengths are applied, with changing addresses and commands. This separates per-edge capture from capture of a level or of the strobe's edge only. Sideband beats are sent with idle gaps between them and with noise on the opposite path. This shows whether beat counting follows the qualifier and whether the unselected path is truly dead.

Bursts past eight entries are also applied, including a push while full in the same cycle as a pop. These tell apart the drop rule and the sticky flag from a FIFO that quietly makes room. A second write of the path select after locking shows whether the lock holds.

// File: rtl/rqi_pkg.sv
package rqi_pkg;
  localparam int ADDR_W = 32;
  localparam int CMD_W  = 4;
  localparam int SB_W   = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
  } req_t;

  typedef enum logic {PATH_STROBE = 1'b0, PATH_SIDE = 1'b1} path_e;
endpackage

// File: rtl/rqi_mode_cfg.sv
module rqi_mode_cfg
  import rqi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  logic  sel,
  output logic  locked,
  output path_e path
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      path   <= PATH_STROBE;
    end else if (wr && !locked) begin
      locked <= 1'b1;
      path   <= path_e'(sel);
    end
  end

  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(path)));
endmodule

// File: rtl/rqi_sb_assembler.sv
module rqi_sb_assembler
  import rqi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            beat_vld,
  input  logic [SB_W-1:0] beat,
  output logic            done,
  output req_t            req
);
  localparam int NBEATS = 4;
  localparam int BW     = $clog2(NBEATS);

  logic [BW-1:0]    idx;
  logic [CMD_W-1:0] cmd_q;
  logic [SB_W-1:0]  hi_q, mid_q;
  logic             take;

  assign take = en && beat_vld;
  assign done = take && (idx == BW'(NBEATS-1));
  assign req.addr = {hi_q, mid_q, beat, {SB_W{1'b0}}};
  assign req.cmd  = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      cmd_q <= '0;
      hi_q  <= '0;
      mid_q <= '0;
    end else if (take) begin
      idx <= idx + 1'b1;
      case (idx)
        BW'(0):  cmd_q <= beat[CMD_W-1:0];
        BW'(1):  hi_q  <= beat;
        BW'(2):  mid_q <= beat;
        default: ;
      endcase
    end
  end

  assert_silent_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(idx));
endmodule

// File: rtl/rqi_fifo.sv
module rqi_fifo
  import rqi_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  req_t push_data,
  output logic out_valid,
  input  logic out_ready,
  output req_t out_data,
  output logic full,
  output logic empty,
  output logic ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  req_t          mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign out_valid = !empty;
  assign out_data  = mem[rp];
  assign do_wr     = push && !full;
  assign do_rd     = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push && full) ovf <= 1'b1;
      if (do_wr) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= push_data;
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !out_ready) |=> full);
  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/req_intake_queue.sv
module req_intake_queue
  import rqi_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  output logic              cfg_locked,
  output logic              mode_sb,
  input  logic              pipe_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              sb_vld,
  input  logic [SB_W-1:0]   sb_data,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [ADDR_W-1:0] deq_addr,
  output logic [CMD_W-1:0]  deq_cmd,
  output logic              q_full,
  output logic              q_empty,
  output logic              overflow
);
  path_e path;
  logic  sb_done, enq;
  req_t  sb_req, strobe_req, enq_req, head;

  rqi_mode_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .locked(cfg_locked), .path(path)
  );

  rqi_sb_assembler u_sb (
    .clk(clk), .rst_n(rst_n),
    .en(cfg_locked && (path == PATH_SIDE)),
    .beat_vld(sb_vld), .beat(sb_data),
    .done(sb_done), .req(sb_req)
  );

  assign strobe_req = '{addr: ad_in, cmd: cmd_in};

  always_comb begin
    enq     = 1'b0;
    enq_req = strobe_req;
    if (cfg_locked) begin
      if (path == PATH_SIDE) begin
        enq     = sb_done;
        enq_req = sb_req;
      end else begin
        enq = !pipe_n;
      end
    end
  end

  rqi_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(enq), .push_data(enq_req),
    .out_valid(deq_valid), .out_ready(deq_ready), .out_data(head),
    .full(q_full), .empty(q_empty), .ovf(overflow)
  );

  assign mode_sb  = (path == PATH_SIDE);
  assign deq_addr = head.addr;
  assign deq_cmd  = head.cmd;

  assert_unlocked_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_locked && q_empty) |=> q_empty);
  assert_strobe_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && !mode_sb && !pipe_n && !q_full && !deq_ready) |=> !q_empty);
  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && !mode_sb && !pipe_n && q_full) |=> overflow);
endmodule

// File: tb/req_intake_queue_tb.sv
module req_intake_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0, cfg_locked, mode_sb;
  logic pipe_n = 1;
  logic [31:0] ad_in = '0;
  logic [3:0] cmd_in = '0;
  logic sb_vld = 0;
  logic [7:0] sb_data = '0;
  logic deq_valid, deq_ready = 0;
  logic [31:0] deq_addr;
  logic [3:0] deq_cmd;
  logic q_full, q_empty, overflow;

  int checks = 0, errors = 0;
  string tag = "R1";

  logic [35:0] mq[$];
  bit m_locked, m_mode, m_ovf;
  int m_beat;
  logic [3:0] m_c;
  logic [7:0] m_b1, m_b2;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_intake_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_locked(cfg_locked), .mode_sb(mode_sb), .pipe_n(pipe_n),
    .ad_in(ad_in), .cmd_in(cmd_in), .sb_vld(sb_vld), .sb_data(sb_data),
    .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_addr(deq_addr),
    .deq_cmd(deq_cmd), .q_full(q_full), .q_empty(q_empty), .overflow(overflow)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit push, full;
    logic [35:0] d;
    full = (mq.size() == DEPTH);
    push = 0;
    d = {ad_in, cmd_in};
    if (m_locked) begin
      if (m_mode) begin
        push = sb_vld && (m_beat == 3);
        d = {m_b1, m_b2, sb_data, 8'h00, m_c};
      end else push = !pipe_n;
    end
    if (push && full) m_ovf = 1;
    if (mq.size() > 0 && deq_ready) void'(mq.pop_front());
    if (push && !full) mq.push_back(d);
    if (m_locked && m_mode && sb_vld) begin
      case (m_beat)
        0: m_c = sb_data[3:0];
        1: m_b1 = sb_data;
        2: m_b2 = sb_data;
        default: ;
      endcase
      m_beat = (m_beat + 1) % 4;
    end
    if (cfg_wr && !m_locked) begin
      m_locked = 1;
      m_mode = cfg_sel;
    end
  endtask

  task automatic compare();
    chk(tag, "deq_valid", deq_valid, mq.size() > 0);
    chk("R8", "q_full", q_full, mq.size() == DEPTH);
    chk("R8", "q_empty", q_empty, mq.size() == 0);
    chk(tag, "overflow", overflow, m_ovf);
    chk(tag, "cfg_locked", cfg_locked, m_locked);
    chk(tag, "mode_sb", mode_sb, m_mode);
    if (mq.size() > 0) chk(tag, "head", {deq_addr, deq_cmd}, mq[0]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst_n = 0;
    cfg_wr = 0; pipe_n = 1; sb_vld = 0; deq_ready = 0;
    mq.delete();
    m_locked = 0; m_mode = 0; m_ovf = 0; m_beat = 0;
    m_c = '0; m_b1 = '0; m_b2 = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1", "q_empty", q_empty, 1);
    chk("R1", "q_full", q_full, 0);
    chk("R1", "deq_valid", deq_valid, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "cfg_locked", cfg_locked, 0);
    chk("R1", "mode_sb", mode_sb, 0);
  endtask

  task automatic sb_beat(logic [7:0] b);
    sb_vld = 1; sb_data = b; tick();
    sb_vld = 0; sb_data = 8'h5A; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R3: requests before the path is chosen are refused
    tag = "R3";
    pipe_n = 0; ad_in = 32'hDEAD0000; cmd_in = 4'h3; tick(); tick();
    pipe_n = 1; sb_vld = 1; sb_data = 8'h11; tick(); sb_vld = 0;
    // R2: lock strobe mode, then a second write is ignored
    tag = "R2";
    cfg_wr = 1; cfg_sel = 0; tick();
    cfg_sel = 1; tick();
    cfg_wr = 0; tick();
    chk("R2", "mode_sb after 2nd write", mode_sb, 0);
    // R4: per-edge capture with deq_ready low
    tag = "R4";
    for (int i = 0; i < 3; i++) begin
      pipe_n = 0; ad_in = 32'h1000_0000 + i * 32'h44; cmd_in = 4'(i + 1); tick();
    end
    // R5 and R6: strobe idle, sideband noise ignored
    tag = "R5";
    pipe_n = 1; ad_in = 32'hBAD; tick();
    tag = "R6";
    for (int i = 0; i < 5; i++) begin sb_vld = 1; sb_data = 8'(i); tick(); end
    sb_vld = 0;
    // R9: overfill
    tag = "R9";
    for (int i = 0; i < 7; i++) begin
      pipe_n = 0; ad_in = 32'h2000_0000 + i; cmd_in = 4'(8 + i); tick();
    end
    chk("R9", "overflow after overfill", overflow, 1);
    pipe_n = 0; ad_in = 32'h3333_3333; deq_ready = 1; tick();
    pipe_n = 1;
    // R10 and R8: drain with stalls, order checked each cycle
    tag = "R10";
    for (int i = 0; i < 20; i++) begin deq_ready = (i % 3 != 0); tick(); end
    deq_ready = 0;
    chk("R8", "empty after drain", q_empty, 1);

    do_reset();
    tag = "R7";
    cfg_wr = 1; cfg_sel = 1; tick(); cfg_wr = 0;
    pipe_n = 0; ad_in = 32'hFFFF_FFFF; tick();
    sb_beat(8'hA7); sb_beat(8'h12); sb_beat(8'h34); sb_beat(8'h56);
    pipe_n = 1;
    sb_vld = 1;
    sb_data = 8'hF2; tick(); sb_data = 8'h9A; tick();
    sb_data = 8'hBC; tick(); sb_data = 8'hDE; tick();
    sb_vld = 0;
    chk("R7", "two entries held", q_empty, 0);
    deq_ready = 1; tick(); tick(); tick();
    chk("R8", "empty after sideband drain", q_empty, 1);
    cfg_wr = 1; cfg_sel = 0; tick(); cfg_wr = 0;
    chk("R2", "sideband mode kept", mode_sb, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule